// File: doc/BRIEF.md
# Vertical Sync Cleaner with Field Parity Detection

This block sits after sync slicing in a video front end. It takes a horizontal and a vertical sync. Both are already single-bit, active-high and synchronous to the pixel clock. It produces a cleaned vertical sync and an odd/even field flag. A vertical pulse reaches the output only after it has been present across a minimum number of horizontal sync leading edges. Shorter glitches never reach the output.

An accepted pulse is replayed one or more lines later, at the same position within the line where its leading edge arrived. If that position lies close to a horizontal sync leading edge, the output edge moves to a fixed guard distance after the line start. The two leading edges therefore never switch together. The line length is measured continuously between horizontal leading edges. The position of the vertical leading edge within the line sets the field flag: an edge in the outer quarters gives one parity, an edge in the middle half gives the other. When the enable is low, the vertical input is wired straight to the output.

Top module: `vsync_field_filter`

## Requirements
- R1: While reset (`rstN` low, sampled on the clock) is applied with the filter enabled, `vsOut` and `fieldOut` are 0, and both remain 0 after reset until a pulse is accepted.
- R2: With `filterEn` low, `vsOut` equals `vsIn` in the same cycle (combinational path), and `fieldOut` holds its value.
- R3: A vertical pulse is accepted when `vsIn` is sampled high on MIN_LINES clock edges that each register an `hsIn` rising edge (counting an edge in the same cycle as the vertical rise). A pulse seen on fewer such edges never raises `vsOut`.
- R4: Let p be the number of clocks from the edge that samples the `hsIn` rise to the edge that samples the `vsIn` rise. On acceptance, `vsOut` rises p clocks after the edge that samples the qualifying `hsIn` rise.
- R5: If p < GUARD_CLKS or p + GUARD_CLKS >= L, where L is the clock count of the line completed at the qualifying edge, `vsOut` rises GUARD_CLKS clocks after that edge instead.
- R6: `vsOut` falls one clock after `vsIn` is sampled low. A pulse that is sampled low on or before the clock of its replayed edge produces no output.
- R7: When `vsOut` rises, `fieldOut` is set to 1 if p < floor(L/4) or p >= L - floor(L/4), and to 0 otherwise. At all other times `fieldOut` holds its value.
- R8: With the filter enabled and line lengths steady, the clock in which `vsOut` rises is never the clock in which `hsIn` rises.
- R9: L is remeasured on every horizontal leading edge, so the same p can yield a different field value for a different line length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous reset, active low |
| filterEn | input | 1 | 1 = filter active, 0 = pass vertical sync through |
| hsIn | input | 1 | Horizontal sync, active high |
| vsIn | input | 1 | Vertical sync, active high |
| vsOut | output | 1 | Cleaned or passed-through vertical sync |
| fieldOut | output | 1 | Field parity: 1 = edge in outer quarters, 0 = middle half |

## Verification
The vertical leading edge is placed mid-line, at both quarter boundaries and one clock inside each, within the guard window at both ends of the line, and exactly on the horizontal edge. These placements separate plain replay from guard shifting and split the two field values at their thresholds. A short pulse checks rejection. A pulse that ends just as its replay is due checks cancellation. The same edge position is tried under two line lengths, which shows that the quadrant limits follow the measured line. A disabled run shows the direct path.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

  // control -> datapath
  typedef struct packed {
    logic arm;   // latch replay target and pending parity
    logic fire;  // commit pending parity to the output
  } vsfStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic hsRise;    // hsync leading edge in this cycle
    logic atTarget;  // line position equals the replay target
  } vsfStatus_t;

endpackage

// File: rtl/vsf_datapath.sv
module vsf_datapath
  import vsf_pkg::*;
#(
  parameter int HPOS_W     = 12,
  parameter int GUARD_CLKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsIn,
  input  logic       vsIn,
  input  vsfStrobe_t strobe,
  output vsfStatus_t status,
  output logic       fieldOut
);

  localparam logic [HPOS_W-1:0] GUARD_V = HPOS_W'(GUARD_CLKS);
  localparam logic [HPOS_W-1:0] POS_MAX = {HPOS_W{1'b1}};

  logic              hsPrev, vsPrev;
  logic              hsRise, vsRise;
  logic [HPOS_W-1:0] hPos;
  logic [HPOS_W-1:0] curPos;
  logic [HPOS_W-1:0] vsPos;
  logic [HPOS_W-1:0] edgePos;
  logic [HPOS_W-1:0] lenNow;
  logic [HPOS_W-1:0] quarter;
  logic [HPOS_W-1:0] upperBound;
  logic [HPOS_W:0]   guardSum;
  logic              nearEdge;
  logic              outerQuad;
  logic [HPOS_W-1:0] target;
  logic              fieldPend;
  logic              fieldReg;

  assign hsRise  = hsIn & ~hsPrev;
  assign vsRise  = vsIn & ~vsPrev;
  assign curPos  = hsRise ? '0 : hPos;
  assign edgePos = vsRise ? curPos : vsPos;
  assign lenNow  = hPos;

  always_comb begin
    quarter    = lenNow >> 2;
    upperBound = lenNow - quarter;
    guardSum   = {1'b0, edgePos} + {1'b0, GUARD_V};
    nearEdge   = (edgePos < GUARD_V) || (guardSum >= {1'b0, lenNow});
    outerQuad  = (edgePos < quarter) || (edgePos >= upperBound);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsPrev    <= 1'b0;
      vsPrev    <= 1'b0;
      hPos      <= '0;
      vsPos     <= '0;
      target    <= '0;
      fieldPend <= 1'b0;
      fieldReg  <= 1'b0;
    end else begin
      hsPrev <= hsIn;
      vsPrev <= vsIn;
      if (hsRise)
        hPos <= HPOS_W'(1);
      else if (hPos != POS_MAX)
        hPos <= hPos + 1'b1;
      if (vsRise)
        vsPos <= curPos;
      if (strobe.arm) begin
        target    <= nearEdge ? GUARD_V : edgePos;
        fieldPend <= outerQuad;
      end
      if (strobe.fire)
        fieldReg <= fieldPend;
    end
  end

  assign status.hsRise   = hsRise;
  assign status.atTarget = !hsRise && (hPos == target);
  assign fieldOut        = fieldReg;

endmodule

// File: rtl/vsf_control.sv
module vsf_control
  import vsf_pkg::*;
#(
  parameter int MIN_LINES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       filterEn,
  input  logic       vsIn,
  input  vsfStatus_t status,
  output vsfStrobe_t strobe,
  output logic       vsFilt
);

  localparam int                CNT_W     = $clog2(MIN_LINES + 1);
  localparam logic [CNT_W-1:0] LAST_LINE = CNT_W'(MIN_LINES - 1);

  logic [CNT_W-1:0] lineCnt;
  logic             qualified;
  logic             armed;
  logic             dropAll;
  logic             countEdge;

  assign dropAll     = !filterEn || !vsIn;
  assign countEdge   = !dropAll && status.hsRise && !qualified;
  assign strobe.arm  = countEdge && (lineCnt >= LAST_LINE);
  assign strobe.fire = !dropAll && armed && status.atTarget;

  always_ff @(posedge clk) begin
    if (!rstN || dropAll) begin
      lineCnt   <= '0;
      qualified <= 1'b0;
      armed     <= 1'b0;
      vsFilt    <= 1'b0;
    end else begin
      if (countEdge)
        lineCnt <= lineCnt + 1'b1;
      if (strobe.arm) begin
        qualified <= 1'b1;
        armed     <= 1'b1;
      end
      if (strobe.fire) begin
        armed  <= 1'b0;
        vsFilt <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vsync_field_filter.sv
module vsync_field_filter
  import vsf_pkg::*;
#(
  parameter int HPOS_W     = 12,
  parameter int GUARD_CLKS = 4,
  parameter int MIN_LINES  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic filterEn,
  input  logic hsIn,
  input  logic vsIn,
  output logic vsOut,
  output logic fieldOut
);

  vsfStrobe_t strobe;
  vsfStatus_t status;
  logic       vsFilt;

  vsf_datapath #(
    .HPOS_W    (HPOS_W),
    .GUARD_CLKS(GUARD_CLKS)
  ) datapath_i (
    .clk     (clk),
    .rstN    (rstN),
    .hsIn    (hsIn),
    .vsIn    (vsIn),
    .strobe  (strobe),
    .status  (status),
    .fieldOut(fieldOut)
  );

  vsf_control #(
    .MIN_LINES(MIN_LINES)
  ) control_i (
    .clk     (clk),
    .rstN    (rstN),
    .filterEn(filterEn),
    .vsIn    (vsIn),
    .status  (status),
    .strobe  (strobe),
    .vsFilt  (vsFilt)
  );

  assign vsOut = filterEn ? vsFilt : vsIn;

endmodule

// File: rtl/vsync_field_filter_chk.sv
module vsync_field_filter_chk (
  input logic clk,
  input logic rstN,
  input logic filterEn,
  input logic hsIn,
  input logic vsIn,
  input logic vsOut,
  input logic fieldOut
);

  always_comb begin
    if (!filterEn) AST_PASS_THROUGH: assert (vsOut == vsIn); // R2
  end

  AST_RISE_NEEDS_VS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsOut) |-> vsIn); // R3

  AST_PROMPT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (filterEn && $past(!vsIn)) |-> !vsOut); // R6

  AST_FIELD_ON_RISE: assert property (@(posedge clk) disable iff (!rstN || !filterEn)
    !$stable(fieldOut) |-> $rose(vsOut)); // R7

  AST_NO_EDGE_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    (filterEn && $past(filterEn) && $rose(vsOut)) |-> !$rose(hsIn)); // R8

endmodule

bind vsync_field_filter vsync_field_filter_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .filterEn(filterEn),
  .hsIn    (hsIn),
  .vsIn    (vsIn),
  .vsOut   (vsOut),
  .fieldOut(fieldOut)
);

// File: tb/vsync_field_filter_tb_top.sv
module vsync_field_filter_tb_top;

  localparam int MINL  = 3;
  localparam int GUARD = 4;
  localparam int HW    = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic filterEn = 1'b1;
  logic hsIn = 1'b0;
  logic vsIn = 1'b0;
  logic vsOut, fieldOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  vsync_field_filter #(.HPOS_W(HW), .GUARD_CLKS(GUARD), .MIN_LINES(MINL)) dut_i (
    .clk(clk), .rstN(rstN), .filterEn(filterEn), .hsIn(hsIn), .vsIn(vsIn),
    .vsOut(vsOut), .fieldOut(fieldOut));

  // behavioural reference, in absolute cycle numbers
  int lastHs = 0, cntM = 0, posM = 0, tgtM = 0;
  bit hsPm = 0, vsPm = 0, doneM = 0, armM = 0, vsF = 0, fpM = 0, fldM = 0;

  always @(posedge clk) begin : refModel
    bit hsR, vsR;
    int p, len, posE, q;
    cyc++;
    hsR = hsIn && !hsPm;
    vsR = vsIn && !vsPm;
    len = cyc - lastHs;
    if (len > (1 << HW) - 1) len = (1 << HW) - 1;
    p = hsR ? 0 : len;
    if (!rstN) begin
      lastHs = cyc + 1; hsPm = 0; vsPm = 0; cntM = 0; posM = 0; tgtM = 0;
      doneM = 0; armM = 0; vsF = 0; fpM = 0; fldM = 0;
    end else begin
      if (filterEn && vsIn && armM && !hsR && p == tgtM) begin
        vsF = 1; fldM = fpM; armM = 0;
      end
      if (!filterEn || !vsIn) begin
        cntM = 0; doneM = 0; armM = 0; vsF = 0;
      end else if (hsR && !doneM) begin
        cntM++;
        if (cntM >= MINL) begin
          posE = vsR ? 0 : posM;
          q = len / 4;
          tgtM = (posE < GUARD || posE + GUARD >= len) ? GUARD : posE;
          fpM = (posE < q || posE >= len - q);
          doneM = 1; armM = 1;
        end
      end
      if (vsR) posM = p;
      if (hsR) lastHs = cyc;
      hsPm = hsIn; vsPm = vsIn;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare on the falling edge, then drive the next inputs
  task automatic tick(bit h, bit v, output bit seen);
    @(negedge clk);
    seen = vsOut;
    if (rstN) begin
      check(vsOut == (filterEn ? vsF : vsIn), curReq, "vsOut vs model", vsOut, filterEn ? vsF : vsIn);
      check(fieldOut == fldM, curReq, "fieldOut vs model", fieldOut, fldM);
    end
    hsIn = h;
    vsIn = v;
  endtask

  task automatic frame(int len, int p, int vsLines, string req, bit expRise);
    int pre, post, riseLine, riseK, qLine, expTgt, q;
    bit seen, near, expFld, fldBefore;
    pre = 2; post = 3; riseLine = -1; riseK = -1;
    curReq = req;
    fldBefore = fieldOut;
    for (int l = 0; l < pre + vsLines + post; l++) begin
      for (int k = 0; k < len; k++) begin
        bit v;
        v = (l > pre || (l == pre && k >= p)) &&
            (l < pre + vsLines || (l == pre + vsLines && k < p));
        tick(k < 8, v, seen);
        if (seen && riseLine < 0 && filterEn && vsIn) begin
          riseLine = l; riseK = k;
        end
      end
    end
    if (!filterEn) begin
      check(fieldOut == fldBefore, "R2", "field held while disabled", fieldOut, fldBefore);
      return;
    end
    if (!expRise) begin
      check(riseLine == -1, req, "no output pulse", riseLine, -1);
      check(fieldOut == fldBefore, req, "field held", fieldOut, fldBefore);
      return;
    end
    near   = (p < GUARD) || (p + GUARD >= len);
    expTgt = near ? GUARD : p;
    q      = len / 4;
    expFld = (p < q) || (p >= len - q);
    qLine  = (p == 0) ? pre + MINL - 1 : pre + MINL;
    check(riseLine == qLine, req, "rise line", riseLine, qLine);
    check(riseK == expTgt + 1, req, "rise position", riseK, expTgt + 1);
    check(fieldOut == expFld, "R7", "field value", fieldOut, expFld);
    check(vsOut == 0, "R6", "output low after pulse", vsOut, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    bit seen;
    repeat (4) tick(0, 0, seen);
    // R1: reset values
    check(vsOut == 0, "R1", "vsOut in reset", vsOut, 0);
    check(fieldOut == 0, "R1", "fieldOut in reset", fieldOut, 0);
    @(negedge clk); rstN = 1'b1;
    for (int k = 0; k < 100; k++) tick(k < 8, 0, seen);
    check(vsOut == 0 && fieldOut == 0, "R1", "outputs idle after reset", {vsOut, fieldOut}, 0);

    frame(100, 50, 5, "R4", 1);   // mid-line, field 0
    frame(100, 10, 5, "R4", 1);   // first quarter, field 1
    frame(100, 2,  5, "R5", 1);   // guard near line start
    frame(100, 98, 5, "R5", 1);   // guard near line end
    frame(100, 0,  5, "R8", 1);   // coincident edges
    frame(100, 30, 2, "R3", 0);   // too short: rejected
    frame(100, 60, 3, "R6", 0);   // ends as replay is due
    frame(100, 74, 5, "R7", 1);   // just inside middle half
    frame(100, 75, 5, "R7", 1);   // first clock of last quarter
    frame(100, 25, 5, "R7", 1);   // first clock of middle half
    frame(100, 24, 5, "R7", 1);   // last clock of first quarter
    frame(120, 85, 5, "R9", 1);   // longer line: field 0
    frame(100, 85, 5, "R9", 1);   // shorter line: field 1
    @(negedge clk); filterEn = 1'b0;
    frame(100, 40, 4, "R2", 0);
    @(negedge clk); filterEn = 1'b1;
    frame(100, 50, 5, "R4", 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule